// File: doc/BRIEF.md
# ADC Interrupt Status and Power Control Unit

This unit sits next to an ADC conversion sequencer. It gathers the sequencer's per-slot events, conversion complete and conversion timed out, into one sticky status word. A software-writable arming mask decides which events may set a flag. A second mask decides which flags may drive the single registered interrupt line. The unit also holds the converter's global configuration: clock gate, power-down and enable. While the converter is not fully running, the unit holds the sequencer and discards its events.

Software reaches the unit through a simple word register port with byte addresses. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge. Flags are never cleared by a read. Software clears a flag by writing 0 to its bit, and a 1 in the written word leaves that bit untouched. An event that arrives in the same cycle as the clear takes priority, so the event is never lost.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset the status, arming mask and line mask read 0. The config register at 0x130 reads 0x8000_0002, which means clock gated, powered down and disabled. `hold_o` is 1 and `irq_o` is 0.
- R2: The sequencer raises `done_evt_i[s]` or `tmo_evt_i[s]` while the converter is running. If the arming mask (0xD0) bit for that event is set, status (0xE0) bit 8+s (done) or 16+s (timeout) reads 1 from the next cycle on.
- R3: An event whose arming-mask bit is 0 leaves the status unchanged.
- R4: Reading the status register does not change it.
- R5: A write to the status register clears every flag whose written bit is 0. Flags whose written bit is 1 keep their value.
- R6: When an event and a software clear hit the same flag in the same cycle, the flag is set afterwards.
- R7: `irq_o` equals the OR over (status AND line mask at 0xC0) as it stood one cycle earlier.
- R8: Config bit 31 drives `clk_off_o`, bit 1 drives `pwr_dn_o` and bit 0 drives `core_en_o`. Config reads back only these three bits.
- R9: While `clk_off_o` is 1, `pwr_dn_o` is 1 or `core_en_o` is 0, `hold_o` is 1 and all events are ignored. Otherwise `hold_o` is 0.
- R10: An access with address bits 1:0 non-zero, or with an address above 0x130, reads 0 and is ignored when it is a write.
- R11: Only bits 8..8+NSLOT-1 and 16..16+NSLOT-1 of the two masks are writable. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| done_evt_i | input | NSLOT | Per-slot conversion-complete pulses |
| tmo_evt_i | input | NSLOT | Per-slot conversion-timeout pulses |
| irq_o | output | 1 | Registered interrupt line |
| hold_o | output | 1 | Hold request to the sequencer |
| clk_off_o | output | 1 | Converter clock gate |
| pwr_dn_o | output | 1 | Converter power-down |
| core_en_o | output | 1 | Converter enable |

## Verification
The bench builds the unit with NSLOT=4 and ADDR_W=12. This fills both flag nibbles, so every done and timeout bit, and every mask bit beside them, is exercised. The 12-bit address also reaches past 0x130, which lets the bench check out-of-range aliases such as 0x1E0 against the status register. A behavioural model tracks the flags, masks, config and the delayed interrupt. Directed steps then cover clear-versus-event collisions, the one-cycle interrupt lag and gated-off event suppression, followed by a randomized mix of events and accesses.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

  localparam int DONE_LSB   = 8;
  localparam int TMO_LSB    = 16;
  localparam int CFG_CLKOFF = 31;
  localparam int CFG_PWRDN  = 1;
  localparam int CFG_EN     = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LINE,
    SEL_ARM,
    SEL_STAT,
    SEL_CFG
  } reg_sel_e;

  typedef struct packed {
    logic clk_off;
    logic pwr_dn;
    logic en;
  } core_cfg_t;

  function automatic logic [31:0] slot_bits(int n);
    logic [31:0] b;
    b = '0;
    for (int i = 0; i < n; i++) begin
      b[DONE_LSB+i] = 1'b1;
      b[TMO_LSB+i]  = 1'b1;
    end
    return b;
  endfunction

endpackage

// File: rtl/adc_irq_decode.sv
module adc_irq_decode import adc_irq_pkg::*; #(
  parameter int ADDR_W   = 12,
  parameter int LINE_OFS = 'hC0,
  parameter int ARM_OFS  = 'hD0,
  parameter int STAT_OFS = 'hE0,
  parameter int CFG_OFS  = 'h130,
  parameter int MAP_TOP  = 'h130
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output reg_sel_e          sel_o
);

  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(LINE_OFS);
  localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(ARM_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(MAP_TOP);

  assign ok_o = (addr_i[1:0] == 2'b00) && (addr_i <= A_TOP);

  always_comb begin
    sel_o = SEL_NONE;
    if (ok_o) begin
      if (addr_i == A_LINE)      sel_o = SEL_LINE;
      else if (addr_i == A_ARM)  sel_o = SEL_ARM;
      else if (addr_i == A_STAT) sel_o = SEL_STAT;
      else if (addr_i == A_CFG)  sel_o = SEL_CFG;
    end
  end

endmodule

// File: rtl/adc_irq_mask.sv
module adc_irq_mask import adc_irq_pkg::*; #(
  parameter int NSLOT = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] mask_o
);

  localparam logic [31:0] KEEP = slot_bits(NSLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i & KEEP;
  end

endmodule

// File: rtl/adc_irq_status.sv
module adc_irq_status import adc_irq_pkg::*; #(
  parameter int NSLOT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [NSLOT-1:0] done_i,
  input  logic [NSLOT-1:0] tmo_i,
  input  logic [31:0]      arm_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      status_o
);

  logic [NSLOT-1:0] done_q;
  logic [NSLOT-1:0] tmo_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic set_done, set_tmo, clr_done, clr_tmo;

    assign set_done = active_i & done_i[s] & arm_i[DONE_LSB+s];
    assign set_tmo  = active_i & tmo_i[s]  & arm_i[TMO_LSB+s];
    assign clr_done = wr_i & ~wdata_i[DONE_LSB+s];
    assign clr_tmo  = wr_i & ~wdata_i[TMO_LSB+s];

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q[s] <= 1'b0;
        tmo_q[s]  <= 1'b0;
      end else begin
        done_q[s] <= set_done | (done_q[s] & ~clr_done);
        tmo_q[s]  <= set_tmo  | (tmo_q[s]  & ~clr_tmo);
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[DONE_LSB +: NSLOT] = done_q;
    status_o[TMO_LSB  +: NSLOT] = tmo_q;
  end

endmodule

// File: rtl/adc_irq_core_cfg.sv
module adc_irq_core_cfg import adc_irq_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output core_cfg_t   cfg_o,
  output logic        active_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '{clk_off: 1'b1, pwr_dn: 1'b1, en: 1'b0};
    end else if (wr_i) begin
      cfg_o.clk_off <= wdata_i[CFG_CLKOFF];
      cfg_o.pwr_dn  <= wdata_i[CFG_PWRDN];
      cfg_o.en      <= wdata_i[CFG_EN];
    end
  end

  assign active_o = cfg_o.en & ~cfg_o.pwr_dn & ~cfg_o.clk_off;

endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl import adc_irq_pkg::*; #(
  parameter int NSLOT    = 4,
  parameter int ADDR_W   = 12,
  parameter int LINE_OFS = 'hC0,
  parameter int ARM_OFS  = 'hD0,
  parameter int STAT_OFS = 'hE0,
  parameter int CFG_OFS  = 'h130,
  parameter int MAP_TOP  = 'h130
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NSLOT-1:0]  done_evt_i,
  input  logic [NSLOT-1:0]  tmo_evt_i,
  output logic              irq_o,
  output logic              hold_o,
  output logic              clk_off_o,
  output logic              pwr_dn_o,
  output logic              core_en_o
);

  logic        acc_ok;
  reg_sel_e    sel;
  logic        wr_go, rd_go;
  logic [31:0] status_w, sig_en_w, int_en_w;
  logic        stat_wr_w;
  core_cfg_t   cfg;
  logic        active;
  logic        irq_q;

  adc_irq_decode #(
    .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .ARM_OFS(ARM_OFS),
    .STAT_OFS(STAT_OFS), .CFG_OFS(CFG_OFS), .MAP_TOP(MAP_TOP)
  ) u_dec (
    .addr_i(addr_i),
    .ok_o  (acc_ok),
    .sel_o (sel)
  );

  assign wr_go     = req_i & we_i & acc_ok;
  assign rd_go     = req_i & ~we_i & acc_ok;
  assign stat_wr_w = wr_go & (sel == SEL_STAT);

  adc_irq_mask #(.NSLOT(NSLOT)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_go & (sel == SEL_LINE)), .wdata_i(wdata_i), .mask_o(sig_en_w)
  );

  adc_irq_mask #(.NSLOT(NSLOT)) u_arm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_go & (sel == SEL_ARM)), .wdata_i(wdata_i), .mask_o(int_en_w)
  );

  adc_irq_core_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_go & (sel == SEL_CFG)), .wdata_i(wdata_i),
    .cfg_o(cfg), .active_o(active)
  );

  adc_irq_status #(.NSLOT(NSLOT)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(active), .done_i(done_evt_i), .tmo_i(tmo_evt_i),
    .arm_i(int_en_w), .wr_i(stat_wr_w), .wdata_i(wdata_i),
    .status_o(status_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_w & sig_en_w);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_go) begin
      case (sel)
        SEL_LINE: rdata_o = sig_en_w;
        SEL_ARM:  rdata_o = int_en_w;
        SEL_STAT: rdata_o = status_w;
        SEL_CFG: begin
          rdata_o[CFG_CLKOFF] = cfg.clk_off;
          rdata_o[CFG_PWRDN]  = cfg.pwr_dn;
          rdata_o[CFG_EN]     = cfg.en;
        end
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o     = irq_q;
  assign hold_o    = ~active;
  assign clk_off_o = cfg.clk_off;
  assign pwr_dn_o  = cfg.pwr_dn;
  assign core_en_o = cfg.en;

endmodule

// File: rtl/adc_irq_ctrl_chk.sv
module adc_irq_ctrl_chk import adc_irq_pkg::*; #(
  parameter int NSLOT   = 4,
  parameter int ADDR_W  = 12,
  parameter int MAP_TOP = 'h130
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [NSLOT-1:0]  done_evt_i,
  input logic [NSLOT-1:0]  tmo_evt_i,
  input logic              irq_o,
  input logic              hold_o,
  input logic              clk_off_o,
  input logic              pwr_dn_o,
  input logic              core_en_o,
  input logic [31:0]       status_w,
  input logic [31:0]       sig_en_w,
  input logic [31:0]       int_en_w,
  input logic              stat_wr_w
);

  localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(MAP_TOP);

  logic [31:0] armed_ev;
  logic        bad_rd;

  always_comb begin
    armed_ev = '0;
    armed_ev[DONE_LSB +: NSLOT] = done_evt_i;
    armed_ev[TMO_LSB  +: NSLOT] = tmo_evt_i;
    armed_ev = armed_ev & int_en_w;
  end

  assign bad_rd = req_i && !we_i && ((addr_i[1:0] != 2'b00) || (addr_i > A_TOP));

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr_w |=> ((status_w & $past(status_w)) == $past(status_w)));

  // also covers R6: an armed event sets its flag even under a clear
  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |=> ((status_w & $past(armed_ev)) == $past(armed_ev)));

  p_quiet_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> ((status_w & ~$past(status_w)) == 32'h0));

  p_run_no_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_o && !pwr_dn_o && !clk_off_o) |-> !hold_o);

  p_irq_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_o == $past(|(status_w & sig_en_w))));

  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_rd |-> (rdata_o == 32'h0));

endmodule

bind adc_irq_ctrl adc_irq_ctrl_chk #(
  .NSLOT(NSLOT), .ADDR_W(ADDR_W), .MAP_TOP(MAP_TOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .done_evt_i(done_evt_i),
  .tmo_evt_i(tmo_evt_i), .irq_o(irq_o), .hold_o(hold_o),
  .clk_off_o(clk_off_o), .pwr_dn_o(pwr_dn_o), .core_en_o(core_en_o),
  .status_w(status_w), .sig_en_w(sig_en_w), .int_en_w(int_en_w),
  .stat_wr_w(stat_wr_w)
);

// File: tb/adc_irq_ctrl_bench.sv
module adc_irq_ctrl_bench;

  localparam int NSLOT = 4;
  localparam int AW    = 12;
  localparam logic [AW-1:0] A_LINE = 12'h0C0;
  localparam logic [AW-1:0] A_ARM  = 12'h0D0;
  localparam logic [AW-1:0] A_STAT = 12'h0E0;
  localparam logic [AW-1:0] A_CFG  = 12'h130;
  localparam logic [31:0]   KEEP   = 32'h000F_0F00;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             req, we;
  logic [AW-1:0]    addr;
  logic [31:0]      wdata, rdata;
  logic [NSLOT-1:0] done_e, tmo_e;
  logic             irq, hold, clk_off, pwr_dn, core_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] m_st, m_arm, m_line;
  logic        m_clkoff, m_pd, m_en, m_irq;

  always #5 clk = ~clk;

  adc_irq_ctrl u_adc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_evt_i(done_e), .tmo_evt_i(tmo_e),
    .irq_o(irq), .hold_o(hold), .clk_off_o(clk_off), .pwr_dn_o(pwr_dn),
    .core_en_o(core_en)
  );

  function automatic bit ok_addr(logic [AW-1:0] a);
    return (a[1:0] == 2'b00) && (a <= 12'h130);
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    if (!ok_addr(a)) return 32'h0;
    case (a)
      A_LINE:  return m_line;
      A_ARM:   return m_arm;
      A_STAT:  return m_st;
      A_CFG:   return {m_clkoff, 29'h0, m_pd, m_en};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic r, input logic w, input logic [AW-1:0] a,
                            input logic [31:0] d, input logic [NSLOT-1:0] de,
                            input logic [NSLOT-1:0] te);
    bit running;
    logic [31:0] setv, nst;
    running = m_en && !m_pd && !m_clkoff;
    setv = 32'h0;
    for (int i = 0; i < NSLOT; i++) begin
      if (de[i] && m_arm[8+i])  setv[8+i]  = 1'b1;
      if (te[i] && m_arm[16+i]) setv[16+i] = 1'b1;
    end
    if (!running) setv = 32'h0;
    m_irq = |(m_st & m_line);
    nst = m_st;
    if (r && w && ok_addr(a)) begin
      case (a)
        A_LINE: m_line = d & KEEP;
        A_ARM:  m_arm  = d & KEEP;
        A_STAT: nst    = m_st & d;
        A_CFG: begin
          m_clkoff = d[31];
          m_pd     = d[1];
          m_en     = d[0];
        end
        default: ;
      endcase
    end
    m_st = nst | setv;
  endtask

  task automatic cyc(input logic r, input logic w, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic [NSLOT-1:0] de,
                     input logic [NSLOT-1:0] te, input string tag,
                     input bit has_exp, input logic [31:0] exp);
    bit exp_hold;
    req = r; we = w; addr = a; wdata = d; done_e = de; tmo_e = te;
    #1;
    if (r && !w) begin
      check(rdata == m_read(a), {tag, " (model)"}, rdata, m_read(a));
      if (has_exp) check(rdata == exp, tag, rdata, exp);
    end
    @(posedge clk);
    model_step(r, w, a, d, de, te);
    @(negedge clk);
    req = 1'b0; we = 1'b0; done_e = '0; tmo_e = '0;
    exp_hold = !(m_en && !m_pd && !m_clkoff);
    check(irq == m_irq, "R7 irq line", {31'h0, irq}, {31'h0, m_irq});
    check(hold == exp_hold, "R9 hold", {31'h0, hold}, {31'h0, exp_hold});
    check({clk_off, pwr_dn, core_en} == {m_clkoff, m_pd, m_en}, "R8 cfg pins",
          {29'h0, clk_off, pwr_dn, core_en}, {29'h0, m_clkoff, m_pd, m_en});
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, '0, '0, tag, 1'b1, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, '0, '0, tag, 1'b0, 32'h0);
  endtask

  task automatic ev(input logic [NSLOT-1:0] de, input logic [NSLOT-1:0] te, input string tag);
    cyc(1'b0, 1'b0, '0, 32'h0, de, te, tag, 1'b0, 32'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst_ni = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    done_e = '0; tmo_e = '0;
    m_st = '0; m_arm = '0; m_line = '0;
    m_clkoff = 1'b1; m_pd = 1'b1; m_en = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check(hold == 1'b1 && irq == 1'b0, "R1 hold/irq after reset", {30'h0, hold, irq}, 32'h2);
    rd(A_CFG,  32'h8000_0002, "R1 cfg reset");
    rd(A_STAT, 32'h0, "R1 status reset");
    rd(A_ARM,  32'h0, "R1 arm reset");
    rd(A_LINE, 32'h0, "R1 line reset");

    // R9 events ignored while off
    wr(A_ARM, 32'h000F_0F00, "R11 arm all");
    ev(4'hF, 4'hF, "R9 events while off");
    rd(A_STAT, 32'h0, "R9 events ignored while powered down");

    // R8 power up
    wr(A_CFG, 32'h1, "R8 power up");
    check(hold == 1'b0, "R9 hold released", {31'h0, hold}, 32'h0);
    check({clk_off, pwr_dn, core_en} == 3'b001, "R8 pins after power up",
          {29'h0, clk_off, pwr_dn, core_en}, 32'h1);

    // R2 events
    ev(4'b0010, 4'b0000, "R2 done slot1");
    rd(A_STAT, 32'h0000_0200, "R2 done slot1 flag");
    ev(4'b0000, 4'b0100, "R2 timeout slot2");
    rd(A_STAT, 32'h0004_0200, "R2 timeout slot2 flag");
    rd(A_STAT, 32'h0004_0200, "R4 read keeps flags");

    // R3 masked events
    wr(A_ARM, 32'h0000_0100, "R3 arm slot0 done only");
    ev(4'b1000, 4'b1000, "R3 unarmed events");
    rd(A_STAT, 32'h0004_0200, "R3 unarmed events ignored");
    rd(A_ARM, 32'h0000_0100, "R11 arm readback");

    // R7 interrupt line
    check(irq == 1'b0, "R7 no irq without line mask", {31'h0, irq}, 32'h0);
    wr(A_LINE, 32'h0000_0200, "R7 line enable slot1");
    check(irq == 1'b0, "R7 one-cycle lag", {31'h0, irq}, 32'h0);
    ev(4'b0000, 4'b0000, "R7 idle");
    check(irq == 1'b1, "R7 irq raised", {31'h0, irq}, 32'h1);

    // R5 write-zero clear
    wr(A_STAT, 32'hFFFF_FDFF, "R5 clear bit9");
    check(irq == 1'b1, "R7 irq still from old status", {31'h0, irq}, 32'h1);
    rd(A_STAT, 32'h0004_0000, "R5 write-zero clears bit9");
    check(irq == 1'b0, "R7 irq drops", {31'h0, irq}, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF, "R5 write ones");
    rd(A_STAT, 32'h0004_0000, "R5 ones keep flags");

    // R6 event beats clear
    wr(A_ARM, 32'h000F_0F00, "R6 arm all");
    cyc(1'b1, 1'b1, A_STAT, 32'h0, 4'b0001, 4'b0000, "R6 clear with event", 1'b0, 32'h0);
    rd(A_STAT, 32'h0000_0100, "R6 event beats clear");

    // R10 invalid accesses
    wr(12'h0E1, 32'h0, "R10 unaligned write");
    rd(A_STAT, 32'h0000_0100, "R10 unaligned write ignored");
    rd(12'h0E1, 32'h0, "R10 unaligned read zero");
    wr(12'h1E0, 32'h0, "R10 out-of-range write");
    rd(A_STAT, 32'h0000_0100, "R10 out-of-range write ignored");
    rd(12'h1E0, 32'h0, "R10 out-of-range read zero");
    rd(12'h134, 32'h0, "R10 past-top read zero");
    wr(12'h230, 32'h0000_0003, "R10 cfg alias write");
    rd(A_CFG, 32'h0000_0001, "R10 cfg alias ignored");

    // R11 writable bits
    wr(A_LINE, 32'hFFFF_FFFF, "R11 line all ones");
    rd(A_LINE, 32'h000F_0F00, "R11 line writable bits");

    // R8 / R9 gating
    wr(A_CFG, 32'hFFFF_FFFF, "R8 cfg all ones");
    rd(A_CFG, 32'h8000_0003, "R8 cfg readback");
    check(hold == 1'b1, "R9 hold with clock gated", {31'h0, hold}, 32'h1);
    ev(4'hF, 4'hF, "R9 events while gated");
    rd(A_STAT, 32'h0000_0100, "R9 events ignored while gated");
    wr(A_CFG, 32'h0000_0003, "R8 power down");
    check(hold == 1'b1, "R9 hold powered down", {31'h0, hold}, 32'h1);
    wr(A_CFG, 32'h0000_0000, "R8 disable");
    check(hold == 1'b1, "R9 hold disabled", {31'h0, hold}, 32'h1);
    wr(A_CFG, 32'h0000_0001, "R8 run");
    check(hold == 1'b0, "R9 hold released again", {31'h0, hold}, 32'h0);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      logic r, w;
      r = ($urandom % 3) == 0;
      w = ($urandom % 2) == 0;
      case ($urandom % 7)
        0: a = A_LINE;
        1: a = A_ARM;
        2, 3: a = A_STAT;
        4: a = A_CFG;
        5: a = 12'h0E2;
        default: a = 12'h1E0;
      endcase
      d = $urandom;
      if (a == A_CFG && ($urandom % 4) != 0) d = 32'h1;
      cyc(r, w, a, d, NSLOT'($urandom), NSLOT'($urandom),
          "R2 R5 R6 mixed traffic", 1'b0, 32'h0);
    end
    rd(A_STAT, m_st, "R4 final status");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

endmodule